// File: doc/BRIEF.md
# Indexed Display Control Register File

This block is the host-visible control surface of a paravirtual display adapter. The host reaches every register through two 32-bit ports. A write to the index port selects a register, and a read or write on the value port then acts on that register. The file holds the adapter identity, the display enable, the requested and current screen size, the colour-format words derived from the surface depth, the command-ring commit status, a guest identifier, the cursor registers and a small scratch array.

Several value-port writes carry side effects:

- Identity writes are filtered.
- Toggling enable invalidates the current size and latches the frame-buffer byte count.
- Committing configuration validates the command-ring header words presented on dedicated inputs.
- A write to the sync register raises a one-cycle pulse toward the command processor and sets a busy flag, which stays set until the processor reports completion.

The display side acknowledges a refresh with `refresh_ack`. That acknowledgement copies the pending size into the current size and clears the invalidated flag.

Top module: `dispreg_file`

## Requirements
- R1: After reset the index reads 0, enable reads 0, config-done and busy are 0, and the identity reads 0x90000002. The index port always reads back the last index written.
- R2: A write to the identity register (index 0) is kept only when the value is 0x90000000, 0x90000001 or 0x90000002; any other value leaves the register unchanged.
- R3: For a surface depth d, index 7 and index 28 read (d+7) with bits [2:0] cleared, and index 12 reads ((d+7)>>3) times the pending width. Indexes 9/10/11 read the red/green/blue masks: for depth 8 they are 0x07/0x38/0xC0, for depth 15 0x1F/0x3E0/0x7C00, for depth 16 0x1F/0x7E0/0xF800, and for depth 24 or 32 0xFF0000/0xFF00/0xFF. Indexes 4 and 5 read 2360 and 1770.
- R4: A write to enable (index 1) stores the value, sets current width and height (indexes 2, 3) to all ones and sets `invalidated`. A zero value clears config-done. A nonzero value latches index 16 as ((d+7)>>3) × pending width × pending height.
- R5: A nonzero write to config-done (index 20) sets it only if all four ring words have bits [1:0] clear, min ≥ 16, max ≤ 0x10000 and max ≥ min + 10240; otherwise the flag keeps its value. A zero write clears it.
- R6: A write to index 6 or 7 whose value differs from the surface depth clears config-done; an equal value leaves it unchanged.
- R7: Writing cursor-on (index 27) with 1 sets the visible bit, 0 clears it, and any other value leaves it unchanged. Cursor id, x and y (indexes 24, 25, 26) read back what was written.
- R8: The capability register (index 17) reads 0x3, or 0xE3 when `cursor_cap` is high.
- R9: Indexes 1024 to 1791 and any unassigned index read zero, and writes to them change no register.
- R10: Indexes 1792 to 1792+SCRATCH_WORDS-1 read and write scratch words. Index 29 reads SCRATCH_WORDS.
- R11: A write to sync (index 21) pulses `sync_pulse` for one cycle and sets `busy`. Indexes 21 and 22 read busy. `proc_done` clears busy.
- R12: `refresh_ack` copies the pending width and height into the current ones and clears `invalidated`.
- R13: A write to the pending width (index 2) or height (index 3) sets `invalidated`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Port select: 0 index port, 1 value port |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected port (combinational) |
| surf_depth | input | 6 | Colour depth of the display surface |
| cursor_cap | input | 1 | Hardware cursor support present |
| ring_min | input | 32 | Ring header: first command byte offset |
| ring_max | input | 32 | Ring header: end byte offset |
| ring_next | input | 32 | Ring header: producer offset |
| ring_stop | input | 32 | Ring header: consumer offset |
| proc_done | input | 1 | Command processor finished; clears busy |
| refresh_ack | input | 1 | Display refresh taken; applies pending size |
| sync_pulse | output | 1 | One-cycle request to the command processor |
| busy | output | 1 | Command processing pending |
| disp_enable | output | 1 | Enable register is nonzero |
| cfg_done | output | 1 | Ring configuration committed |
| invalidated | output | 1 | Screen needs a full redraw |
| cursor_visible | output | 1 | Cursor visibility bit |

## Verification
`host_rdata` is combinational, so the bench settles each register read within the same cycle: it drives index and port select on a falling edge and samples one time unit later. Writes take effect at the next rising edge. Flag outputs such as `cfg_done`, `invalidated` and `busy` are therefore sampled on the falling edge that follows the write strobe. `sync_pulse` is checked high on that same falling edge and low one cycle later.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

    typedef logic [31:0] word_t;

    // identity values
    localparam word_t ID_BASE  = 32'h9000_0000;
    localparam word_t ID_RESET = ID_BASE | 32'd2;

    // register indexes decoded by host software
    localparam word_t IX_ID      = 32'd0;
    localparam word_t IX_ENABLE  = 32'd1;
    localparam word_t IX_WIDTH   = 32'd2;
    localparam word_t IX_HEIGHT  = 32'd3;
    localparam word_t IX_MAXW    = 32'd4;
    localparam word_t IX_MAXH    = 32'd5;
    localparam word_t IX_DEPTH   = 32'd6;
    localparam word_t IX_BPP     = 32'd7;
    localparam word_t IX_PSEUDO  = 32'd8;
    localparam word_t IX_RMASK   = 32'd9;
    localparam word_t IX_GMASK   = 32'd10;
    localparam word_t IX_BMASK   = 32'd11;
    localparam word_t IX_PITCH   = 32'd12;
    localparam word_t IX_FBSIZE  = 32'd16;
    localparam word_t IX_CAPS    = 32'd17;
    localparam word_t IX_CFG     = 32'd20;
    localparam word_t IX_SYNC    = 32'd21;
    localparam word_t IX_BUSY    = 32'd22;
    localparam word_t IX_GUEST   = 32'd23;
    localparam word_t IX_CUR_ID  = 32'd24;
    localparam word_t IX_CUR_X   = 32'd25;
    localparam word_t IX_CUR_Y   = 32'd26;
    localparam word_t IX_CUR_ON  = 32'd27;
    localparam word_t IX_HOSTBPP = 32'd28;
    localparam word_t IX_SCRSIZE = 32'd29;

    localparam word_t PAL_FIRST  = 32'd1024;
    localparam word_t PAL_LAST   = 32'd1791;
    localparam word_t SCR_FIRST  = 32'd1792;

    localparam word_t MAX_W = 32'd2360;
    localparam word_t MAX_H = 32'd1770;

    localparam word_t CAP_BASE   = 32'h0000_0003;
    localparam word_t CAP_CURSOR = 32'h0000_00E0;

    localparam word_t RING_HDR_BYTES = 32'd16;
    localparam word_t RING_LIMIT     = 32'h0001_0000;
    localparam word_t RING_MIN_SPAN  = 32'd10240;

    typedef struct packed {
        word_t red;
        word_t green;
        word_t blue;
    } cmask_t;

    typedef struct packed {
        word_t idx;
        word_t id;
        word_t enable;
        logic  cfg;
        word_t cur_w;
        word_t cur_h;
        word_t new_w;
        word_t new_h;
        logic  inval;
        word_t fb_size;
        word_t guest;
        word_t cur_id;
        word_t cur_x;
        word_t cur_y;
        logic  cur_on;
        logic  busy;
        logic  sync_pulse;
    } state_t;

    function automatic logic id_legal(word_t v);
        return (v == ID_BASE) || (v == (ID_BASE | 32'd1)) || (v == (ID_BASE | 32'd2));
    endfunction

endpackage

// File: rtl/dispreg_fmt.sv
module dispreg_fmt
    import dispreg_pkg::*;
#(
    parameter int DEPTH_W = 6
) (
    input  logic [DEPTH_W-1:0] depth,
    output word_t              bits_pp,
    output word_t              bytes_pp,
    output cmask_t             masks
);
    localparam int PAD_W = 32 - DEPTH_W;

    word_t depth_w;
    word_t rounded;

    always_comb begin
        depth_w  = {{PAD_W{1'b0}}, depth};
        rounded  = depth_w + 32'd7;
        bits_pp  = rounded & ~32'd7;
        bytes_pp = rounded >> 3;
        case (depth_w)
            32'd8:   masks = '{red: 32'h07, green: 32'h38, blue: 32'hC0};
            32'd15:  masks = '{red: 32'h1F, green: 32'h3E0, blue: 32'h7C00};
            32'd16:  masks = '{red: 32'h1F, green: 32'h7E0, blue: 32'hF800};
            32'd24,
            32'd32:  masks = '{red: 32'hFF_0000, green: 32'hFF00, blue: 32'hFF};
            default: masks = '0;
        endcase
    end

endmodule

// File: rtl/dispreg_ring_check.sv
module dispreg_ring_check
    import dispreg_pkg::*;
(
    input  word_t ring_min,
    input  word_t ring_max,
    input  word_t ring_next,
    input  word_t ring_stop,
    output logic  hdr_ok
);
    logic        aligned;
    logic        min_ok;
    logic        max_ok;
    logic        span_ok;
    logic [32:0] min_plus;

    always_comb begin
        aligned  = ((ring_min | ring_max | ring_next | ring_stop) & 32'd3) == 32'd0;
        min_ok   = ring_min >= RING_HDR_BYTES;
        max_ok   = ring_max <= RING_LIMIT;
        min_plus = {1'b0, ring_min} + {1'b0, RING_MIN_SPAN};
        span_ok  = {1'b0, ring_max} >= min_plus;
        hdr_ok   = aligned && min_ok && max_ok && span_ok;
    end

endmodule

// File: rtl/dispreg_scratch.sv
module dispreg_scratch
    import dispreg_pkg::*;
#(
    parameter int WORDS = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  word_t index,
    input  word_t wdata,
    output logic  hit,
    output word_t rdata
);
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam word_t LAST = SCR_FIRST + WORDS;

    word_t           offset;
    logic [AW-1:0]   slot;
    word_t           mem_q [WORDS];
    word_t           mem_d [WORDS];

    always_comb begin
        hit    = (index >= SCR_FIRST) && (index < LAST);
        offset = index - SCR_FIRST;
        slot   = offset[AW-1:0];
        rdata  = hit ? mem_q[slot] : '0;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && hit && (slot == AW'(g))) begin
                mem_d[g] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

endmodule

// File: rtl/dispreg_file.sv
module dispreg_file
    import dispreg_pkg::*;
#(
    parameter int SCRATCH_WORDS = 8,
    parameter int DEPTH_W       = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_sel,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic [DEPTH_W-1:0] surf_depth,
    input  logic               cursor_cap,
    input  logic [31:0]        ring_min,
    input  logic [31:0]        ring_max,
    input  logic [31:0]        ring_next,
    input  logic [31:0]        ring_stop,
    input  logic               proc_done,
    input  logic               refresh_ack,
    output logic               sync_pulse,
    output logic               busy,
    output logic               disp_enable,
    output logic               cfg_done,
    output logic               invalidated,
    output logic               cursor_visible
);
    localparam int    PAD_W      = 32 - DEPTH_W;
    localparam word_t SCR_COUNT  = word_t'(SCRATCH_WORDS);

    state_t st_q;
    state_t st_d;

    word_t  bits_pp;
    word_t  bytes_pp;
    cmask_t masks;
    logic   hdr_ok;
    logic   scr_hit;
    word_t  scr_rdata;
    logic   val_we;
    word_t  depth_w;
    word_t  pitch;
    word_t  fb_bytes;

    dispreg_fmt #(.DEPTH_W(DEPTH_W)) u_fmt (
        .depth    (surf_depth),
        .bits_pp  (bits_pp),
        .bytes_pp (bytes_pp),
        .masks    (masks)
    );

    dispreg_ring_check u_ring (
        .ring_min  (ring_min),
        .ring_max  (ring_max),
        .ring_next (ring_next),
        .ring_stop (ring_stop),
        .hdr_ok    (hdr_ok)
    );

    dispreg_scratch #(.WORDS(SCRATCH_WORDS)) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (val_we),
        .index (st_q.idx),
        .wdata (host_wdata),
        .hit   (scr_hit),
        .rdata (scr_rdata)
    );

    assign val_we   = host_we && host_sel;
    assign depth_w  = {{PAD_W{1'b0}}, surf_depth};
    assign pitch    = word_t'(bytes_pp * st_q.new_w);
    assign fb_bytes = word_t'(pitch * st_q.new_h);

    // next-state computation
    always_comb begin
        st_d            = st_q;
        st_d.sync_pulse = 1'b0;

        if (proc_done) begin
            st_d.busy = 1'b0;
        end

        if (refresh_ack) begin
            st_d.cur_w = st_q.new_w;
            st_d.cur_h = st_q.new_h;
            st_d.inval = 1'b0;
        end

        if (host_we && !host_sel) begin
            st_d.idx = host_wdata;
        end

        if (val_we) begin
            case (st_q.idx)
                IX_ID: begin
                    if (id_legal(host_wdata)) begin
                        st_d.id = host_wdata;
                    end
                end
                IX_ENABLE: begin
                    st_d.enable = host_wdata;
                    st_d.cur_w  = '1;
                    st_d.cur_h  = '1;
                    st_d.inval  = 1'b1;
                    if (host_wdata == '0) begin
                        st_d.cfg = 1'b0;
                    end else begin
                        st_d.fb_size = fb_bytes;
                    end
                end
                IX_WIDTH: begin
                    st_d.new_w = host_wdata;
                    st_d.inval = 1'b1;
                end
                IX_HEIGHT: begin
                    st_d.new_h = host_wdata;
                    st_d.inval = 1'b1;
                end
                IX_DEPTH, IX_BPP: begin
                    if (host_wdata != depth_w) begin
                        st_d.cfg = 1'b0;
                    end
                end
                IX_CFG: begin
                    if (host_wdata == '0) begin
                        st_d.cfg = 1'b0;
                    end else if (hdr_ok) begin
                        st_d.cfg = 1'b1;
                    end
                end
                IX_SYNC: begin
                    st_d.busy       = 1'b1;
                    st_d.sync_pulse = 1'b1;
                end
                IX_GUEST:  st_d.guest  = host_wdata;
                IX_CUR_ID: st_d.cur_id = host_wdata;
                IX_CUR_X:  st_d.cur_x  = host_wdata;
                IX_CUR_Y:  st_d.cur_y  = host_wdata;
                IX_CUR_ON: begin
                    if (host_wdata == 32'd1) begin
                        st_d.cur_on = 1'b1;
                    end else if (host_wdata == 32'd0) begin
                        st_d.cur_on = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.id    <= ID_RESET;
            st_q.cur_w <= '1;
            st_q.cur_h <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // read path: no side effects, combinational
    always_comb begin
        host_rdata = '0;
        if (!host_sel) begin
            host_rdata = st_q.idx;
        end else begin
            case (st_q.idx)
                IX_ID:      host_rdata = st_q.id;
                IX_ENABLE:  host_rdata = st_q.enable;
                IX_WIDTH:   host_rdata = st_q.cur_w;
                IX_HEIGHT:  host_rdata = st_q.cur_h;
                IX_MAXW:    host_rdata = MAX_W;
                IX_MAXH:    host_rdata = MAX_H;
                IX_DEPTH:   host_rdata = depth_w;
                IX_BPP:     host_rdata = bits_pp;
                IX_PSEUDO:  host_rdata = '0;
                IX_RMASK:   host_rdata = masks.red;
                IX_GMASK:   host_rdata = masks.green;
                IX_BMASK:   host_rdata = masks.blue;
                IX_PITCH:   host_rdata = pitch;
                IX_FBSIZE:  host_rdata = st_q.fb_size;
                IX_CAPS:    host_rdata = cursor_cap ? (CAP_BASE | CAP_CURSOR) : CAP_BASE;
                IX_CFG:     host_rdata = {31'd0, st_q.cfg};
                IX_SYNC,
                IX_BUSY:    host_rdata = {31'd0, st_q.busy};
                IX_GUEST:   host_rdata = st_q.guest;
                IX_CUR_ID:  host_rdata = st_q.cur_id;
                IX_CUR_X:   host_rdata = st_q.cur_x;
                IX_CUR_Y:   host_rdata = st_q.cur_y;
                IX_CUR_ON:  host_rdata = {31'd0, st_q.cur_on};
                IX_HOSTBPP: host_rdata = bits_pp;
                IX_SCRSIZE: host_rdata = SCR_COUNT;
                default:    host_rdata = scr_hit ? scr_rdata : '0;
            endcase
        end
    end

    assign sync_pulse     = st_q.sync_pulse;
    assign busy           = st_q.busy;
    assign disp_enable    = |st_q.enable;
    assign cfg_done       = st_q.cfg;
    assign invalidated    = st_q.inval;
    assign cursor_visible = st_q.cur_on;

endmodule

// File: rtl/dispreg_file_chk.sv
module dispreg_file_chk
    import dispreg_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  host_we,
    input logic  host_sel,
    input word_t host_wdata,
    input word_t ring_max,
    input word_t idx,
    input word_t id_reg,
    input logic  sync_pulse,
    input logic  busy,
    input logic  cfg_done,
    input logic  cursor_visible
);
    logic vw;
    assign vw = host_we && host_sel;

    assert_id_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vw && idx == IX_ID && !id_legal(host_wdata)) |=> $stable(id_reg));

    assert_cursor_hide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vw && idx == IX_CUR_ON && host_wdata == 32'd0) |=> !cursor_visible);

    assert_cursor_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vw && idx == IX_CUR_ON && host_wdata > 32'd1) |=> $stable(cursor_visible));

    assert_sync_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (vw && idx == IX_SYNC) |=> (sync_pulse && busy));

    assert_enable_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vw && idx == IX_ENABLE && host_wdata == 32'd0) |=> !cfg_done);

    assert_cfg_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(vw && idx == IX_CFG && ring_max <= RING_LIMIT));

endmodule

bind dispreg_file dispreg_file_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_we        (host_we),
    .host_sel       (host_sel),
    .host_wdata     (host_wdata),
    .ring_max       (ring_max),
    .idx            (st_q.idx),
    .id_reg         (st_q.id),
    .sync_pulse     (sync_pulse),
    .busy           (busy),
    .cfg_done       (cfg_done),
    .cursor_visible (cursor_visible)
);

// File: tb/dispreg_file_bench.sv
`timescale 1ns/1ps
module dispreg_file_bench;

    localparam int NSCR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [5:0]  surf_depth = 6'd32;
    logic        cursor_cap = 1'b0;
    logic [31:0] ring_min = '0, ring_max = '0, ring_next = '0, ring_stop = '0;
    logic        proc_done = 1'b0;
    logic        refresh_ack = 1'b0;
    logic        sync_pulse, busy, disp_enable, cfg_done, invalidated, cursor_visible;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dispreg_file #(.SCRATCH_WORDS(NSCR)) u_dispreg_file (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .surf_depth(surf_depth),
        .cursor_cap(cursor_cap), .ring_min(ring_min), .ring_max(ring_max),
        .ring_next(ring_next), .ring_stop(ring_stop), .proc_done(proc_done),
        .refresh_ack(refresh_ack), .sync_pulse(sync_pulse), .busy(busy),
        .disp_enable(disp_enable), .cfg_done(cfg_done), .invalidated(invalidated),
        .cursor_visible(cursor_visible)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wreg(input logic [31:0] ix, input logic [31:0] v);
        wr(1'b0, ix);
        wr(1'b1, v);
    endtask

    task automatic rreg(input logic [31:0] ix, output logic [31:0] v);
        wr(1'b0, ix);
        host_sel = 1'b1;
        #1 v = host_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); refresh_ack = 1'b1;
        @(negedge clk); refresh_ack = 1'b0;
    endtask

    task automatic set_ring(input logic [31:0] mn, mx, nx, sp);
        ring_min = mn; ring_max = mx; ring_next = nx; ring_stop = sp;
    endtask

    function automatic logic [31:0] exp_mask(input int d, input int c);
        logic [31:0] r, g, b;
        case (d)
            8:  begin r = 32'h07; g = 32'h38; b = 32'hC0; end
            15: begin r = 32'h1F; g = 32'h3E0; b = 32'h7C00; end
            16: begin r = 32'h1F; g = 32'h7E0; b = 32'hF800; end
            24, 32: begin r = 32'hFF0000; g = 32'hFF00; b = 32'hFF; end
            default: begin r = 0; g = 0; b = 0; end
        endcase
        return (c == 0) ? r : (c == 1) ? g : b;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] id_exp;
        int dlist[5];
        dlist = '{8, 15, 16, 24, 32};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_sel = 1'b0; #1 chk("R1 reset index", host_rdata, 32'd0);
        chk("R1 reset cfg_done", {31'd0, cfg_done}, 0);
        chk("R1 reset busy", {31'd0, busy}, 0);
        chk("R1 reset enable out", {31'd0, disp_enable}, 0);
        rreg(0, v); chk("R1 reset identity", v, 32'h9000_0002);
        rreg(1, v); chk("R1 reset enable reg", v, 0);
        for (int i = 0; i < 4; i++) begin
            wr(1'b0, 32'h55 + i * 1000);
            host_sel = 1'b0; #1 chk("R1 index readback", host_rdata, 32'h55 + i * 1000);
        end

        // R2 identity filter sweep
        id_exp = 32'h9000_0002;
        for (int ver = 7; ver >= 0; ver--) begin
            wreg(0, 32'h9000_0000 | ver);
            if (ver <= 2) id_exp = 32'h9000_0000 | ver;
            rreg(0, v); chk("R2 identity filter", v, id_exp);
        end
        wreg(0, 32'h1234_5678);
        rreg(0, v); chk("R2 identity junk ignored", v, id_exp);

        // R3 derived formats over depths
        wreg(2, 640);
        for (int k = 0; k < 5; k++) begin
            surf_depth = 6'(dlist[k]);
            rreg(7, v);  chk("R3 bits per pixel", v, ((dlist[k] + 7) / 8) * 8);
            rreg(28, v); chk("R3 host bits per pixel", v, ((dlist[k] + 7) / 8) * 8);
            rreg(12, v); chk("R3 bytes per line", v, ((dlist[k] + 7) / 8) * 640);
            rreg(9, v);  chk("R3 red mask", v, exp_mask(dlist[k], 0));
            rreg(10, v); chk("R3 green mask", v, exp_mask(dlist[k], 1));
            rreg(11, v); chk("R3 blue mask", v, exp_mask(dlist[k], 2));
        end
        rreg(4, v); chk("R3 max width", v, 2360);
        rreg(5, v); chk("R3 max height", v, 1770);

        // R8 capabilities
        cursor_cap = 1'b0; rreg(17, v); chk("R8 caps no cursor", v, 32'h3);
        cursor_cap = 1'b1; #1 v = host_rdata; chk("R8 caps cursor", v, 32'hE3);

        // R13 / R12 / R4 sizing and enable
        surf_depth = 6'd32;
        pulse_ack();
        chk("R12 ack clears invalidated", {31'd0, invalidated}, 0);
        wreg(3, 480);
        chk("R13 height write invalidates", {31'd0, invalidated}, 1);
        pulse_ack();
        rreg(2, v); chk("R12 current width", v, 640);
        rreg(3, v); chk("R12 current height", v, 480);
        wreg(2, 800);
        chk("R13 width write invalidates", {31'd0, invalidated}, 1);
        wreg(2, 640);
        pulse_ack();
        wreg(1, 1);
        chk("R4 enable sets invalidated", {31'd0, invalidated}, 1);
        chk("R4 enable output", {31'd0, disp_enable}, 1);
        rreg(2, v); chk("R4 width all ones", v, 32'hFFFF_FFFF);
        rreg(3, v); chk("R4 height all ones", v, 32'hFFFF_FFFF);
        rreg(16, v); chk("R4 frame size", v, 4 * 640 * 480);
        surf_depth = 6'd16;
        wreg(1, 1);
        rreg(16, v); chk("R4 frame size depth 16", v, 2 * 640 * 480);
        surf_depth = 6'd32;

        // R5 configuration commit
        set_ring(16, 32'h10000, 16, 16);
        wreg(20, 1);
        chk("R5 valid header commits", {31'd0, cfg_done}, 1);
        set_ring(16, 32'h10004, 16, 16);
        wreg(20, 1);
        chk("R5 failed commit keeps set", {31'd0, cfg_done}, 1);
        wreg(20, 0);
        chk("R5 zero clears", {31'd0, cfg_done}, 0);
        for (int f = 0; f < 6; f++) begin
            case (f)
                0: set_ring(18, 32'h10000, 16, 16);
                1: set_ring(16, 32'h10000, 17, 16);
                2: set_ring(16, 32'h10000, 16, 18);
                3: set_ring(12, 32'h10000, 16, 16);
                4: set_ring(16, 32'h10004, 16, 16);
                default: set_ring(16, 10252, 16, 16);
            endcase
            wreg(20, 1);
            chk("R5 bad header rejected", {31'd0, cfg_done}, 0);
        end
        set_ring(16, 10256, 16, 16);
        wreg(20, 5);
        chk("R5 exact span accepted", {31'd0, cfg_done}, 1);
        rreg(20, v); chk("R5 cfg reads one", v, 1);

        // R6 depth mismatch
        wreg(6, 32);
        chk("R6 equal depth keeps cfg", {31'd0, cfg_done}, 1);
        wreg(7, 24);
        chk("R6 mismatch clears cfg", {31'd0, cfg_done}, 0);
        wreg(20, 1);
        wreg(6, 16);
        chk("R6 depth reg mismatch clears", {31'd0, cfg_done}, 0);
        wreg(20, 1);
        wreg(1, 0);
        chk("R4 disable clears cfg", {31'd0, cfg_done}, 0);
        chk("R4 disable output", {31'd0, disp_enable}, 0);

        // R7 cursor
        begin
            int seq[8];
            logic on_exp;
            seq = '{1, 2, 3, 0, 3, 2, 1, 5};
            on_exp = 1'b0;
            for (int s = 0; s < 8; s++) begin
                wreg(27, seq[s]);
                if (seq[s] == 1) on_exp = 1'b1;
                else if (seq[s] == 0) on_exp = 1'b0;
                chk("R7 cursor visible", {31'd0, cursor_visible}, {31'd0, on_exp});
            end
        end
        wreg(24, 7); wreg(25, 123); wreg(26, 456);
        rreg(24, v); chk("R7 cursor id", v, 7);
        rreg(25, v); chk("R7 cursor x", v, 123);
        rreg(26, v); chk("R7 cursor y", v, 456);

        // R10 scratch
        for (int w = 0; w < NSCR; w++) wreg(1792 + w, 32'hA000_0000 + w * 17);
        for (int w = 0; w < NSCR; w++) begin
            rreg(1792 + w, v); chk("R10 scratch word", v, 32'hA000_0000 + w * 17);
        end
        rreg(29, v); chk("R10 scratch size", v, NSCR);
        wreg(1792 + NSCR, 32'hDEAD);
        rreg(1792 + NSCR, v); chk("R10 past scratch reads zero", v, 0);

        // R9 palette and unknown indexes
        wreg(1024, 32'hFFFF); rreg(1024, v); chk("R9 palette first", v, 0);
        wreg(1791, 32'hFFFF); rreg(1791, v); chk("R9 palette last", v, 0);
        wreg(40, 32'h77); rreg(40, v); chk("R9 unknown index", v, 0);
        rreg(1792, v); chk("R9 scratch untouched", v, 32'hA000_0000);
        rreg(0, v); chk("R9 identity untouched", v, id_exp);

        // R11 sync and busy
        wreg(21, 1);
        chk("R11 sync pulse high", {31'd0, sync_pulse}, 1);
        chk("R11 busy set", {31'd0, busy}, 1);
        @(negedge clk);
        chk("R11 sync pulse one cycle", {31'd0, sync_pulse}, 0);
        rreg(22, v); chk("R11 busy register", v, 1);
        rreg(21, v); chk("R11 sync register reads busy", v, 1);
        @(negedge clk); proc_done = 1'b1;
        @(negedge clk); proc_done = 1'b0;
        chk("R11 done clears busy", {31'd0, busy}, 0);
        rreg(22, v); chk("R11 busy register cleared", v, 0);

        // R1 reset again clears state
        wreg(20, 1); wreg(1, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset clears cfg", {31'd0, cfg_done}, 0);
        chk("R1 reset clears enable", {31'd0, disp_enable}, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule